// File: doc/BRIEF.md
# Prescaled 16-bit Timer Counter

This block is a 16-bit timer counter that advances only on ticks from its own prescaler, which divides the block clock by 1, 8 or 128. A two-bit mode field in the control register either halts the counter or runs it in one of three ways: free-running with a wrap at the top of the range, modulo against a programmable limit, or up/down between zero and the limit. The up/down mode is the one used to build centre-aligned PWM.

Software reaches the block through a plain 8-bit register bus with separate read and write strobes. Read data is combinational from the address during a read cycle. There is no back-pressure: every strobe is accepted in the cycle it is presented. The counter is read as two bytes. Reading the low byte also copies the high byte into a holding register, and the high-byte address returns that copy, so a low-then-high read pair gives a coherent 16-bit value. Any write to the low-byte address clears the counter.

A sticky flag records each terminal event and drives the interrupt output. Software clears the flag by writing a 1 to it.

Top module: `tmr16_unit`

## Requirements
- R1: The counter changes by exactly one on each prescaler tick and holds its value between ticks. In free-running mode it counts up and wraps from 0xFFFF to 0x0000.
- R2: Control bits [3:2] select the prescaler ratio: 00 = 1, 01 = 8, 10 or 11 = 128. With ratio N, the k-th step after a start lands on the (k*N)-th clock edge after the start write.
- R3: Control bits [1:0] select the mode: 00 = stopped, 01 = free-running, 10 = modulo, 11 = up/down. When stopped, the counter holds its value indefinitely.
- R4: In modulo mode the counter wraps from the limit to 0. In up/down mode it counts up to the limit, then down to 0, then up again, and the direction survives a stop. The limit is a 16-bit register: low byte at address 3, high byte at address 4.
- R5: A read of address 0 returns the counter's low byte and copies its high byte into a holding register. A read of address 1 returns that holding register and not the live count.
- R6: Any write to address 0 sets the counter to 0, restarts the prescaler and sets the up/down direction to up. The written data is ignored.
- R7: The flag (status address 5, bit 0, also driven on `irq`) is set when the counter wraps to 0 in free-running or modulo mode, or reaches 0 while counting down in up/down mode.
- R8: The flag is sticky. Writing a status byte with bit 0 set clears it. Writing 0 leaves it unchanged. A new event in the same cycle as a clear wins.
- R9: The prescaler restarts from zero while the counter is stopped or cleared, so the first step after a start always takes a full ratio period. A ratio change made while running takes effect at the next prescaler terminal count.
- R10: After reset: counter 0, control 0, holding register 0, flag 0, limit 0xFFFF. Reads of unused addresses return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_wr | input | 1 | Write strobe, one cycle per access |
| reg_rd | input | 1 | Read strobe, one cycle per access |
| reg_rdata | output | 8 | Read data, valid during the read strobe |
| irq | output | 1 | Sticky terminal-event flag |

## Verification
A wrong prescaler phase or ratio shows up at the ports as a count that is off by one step. This appears on the very next stopped read, because the bench brackets each run with an exact number of clock edges. A lost up/down direction or a wrong modulo compare changes the byte read after a handful of ticks, and it also moves the moment the flag first appears in the status byte. A holding register that follows the live count, instead of the last low-byte read, becomes visible as soon as the counter's high byte changes between the two halves of a read pair.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;

  typedef enum logic [1:0] {
    MD_STOP = 2'b00,
    MD_FREE = 2'b01,
    MD_MOD  = 2'b10,
    MD_UPDN = 2'b11
  } tmr_mode_e;

  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_CNT_LO = 3'd0;
  localparam logic [ADDR_W-1:0] A_CNT_HI = 3'd1;
  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd2;
  localparam logic [ADDR_W-1:0] A_LIM_LO = 3'd3;
  localparam logic [ADDR_W-1:0] A_LIM_HI = 3'd4;
  localparam logic [ADDR_W-1:0] A_STAT   = 3'd5;

endpackage

// File: rtl/tmr16_prescaler.sv
module tmr16_prescaler #(
  parameter int DIV_MID = 8,
  parameter int DIV_MAX = 128
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       restart,
  input  logic [1:0] div_sel,
  output logic       tick
);
  localparam int PRE_W = $clog2(DIV_MAX);

  logic [PRE_W-1:0] pre_cnt;
  logic [PRE_W-1:0] act_lim;
  logic [PRE_W-1:0] sel_lim;

  // terminal value for each ratio selection
  always_comb begin
    case (div_sel)
      2'b00:   sel_lim = '0;
      2'b01:   sel_lim = PRE_W'(DIV_MID - 1);
      default: sel_lim = PRE_W'(DIV_MAX - 1);
    endcase
  end

  assign tick = run && !restart && (pre_cnt == act_lim);

  // ratio is sampled only at a restart or at a terminal count
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_cnt <= '0;
      act_lim <= '0;
    end else if (!run || restart || tick) begin
      pre_cnt <= '0;
      act_lim <= sel_lim;
    end else begin
      pre_cnt <= pre_cnt + 1'b1;
    end
  end

endmodule

// File: rtl/tmr16_counter.sv
module tmr16_counter
  import tmr16_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             clr,
  input  tmr_mode_e        mode,
  input  logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] cnt,
  output logic             evt
);
  localparam logic [CNT_W-1:0] TOP = '1;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic             dn_q;
  logic             dn_nxt;
  logic [CNT_W-1:0] cnt_nxt;
  logic             hit;

  always_comb begin
    cnt_nxt = cnt;
    dn_nxt  = dn_q;
    hit     = 1'b0;
    if (mode == MD_FREE || mode == MD_MOD) dn_nxt = 1'b0;
    if (tick) begin
      case (mode)
        MD_FREE: begin
          if (cnt == TOP) begin
            cnt_nxt = '0;
            hit     = 1'b1;
          end else begin
            cnt_nxt = cnt + ONE;
          end
        end
        MD_MOD: begin
          if (cnt == limit || cnt == TOP) begin
            cnt_nxt = '0;
            hit     = 1'b1;
          end else begin
            cnt_nxt = cnt + ONE;
          end
        end
        MD_UPDN: begin
          if (!dn_q) begin
            if (cnt < limit) begin
              cnt_nxt = cnt + ONE;
            end else if (cnt == '0) begin
              hit = 1'b1;
            end else begin
              cnt_nxt = cnt - ONE;
              dn_nxt  = 1'b1;
            end
          end else if (cnt <= ONE) begin
            cnt_nxt = '0;
            dn_nxt  = 1'b0;
            hit     = 1'b1;
          end else begin
            cnt_nxt = cnt - ONE;
          end
        end
        default: cnt_nxt = cnt;
      endcase
    end
  end

  assign evt = hit && !clr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      dn_q <= 1'b0;
    end else if (clr) begin
      cnt  <= '0;
      dn_q <= 1'b0;
    end else begin
      cnt  <= cnt_nxt;
      dn_q <= dn_nxt;
    end
  end

endmodule

// File: rtl/tmr16_regfile.sv
module tmr16_regfile
  import tmr16_pkg::*;
#(
  parameter int BUS_W = 8,
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BUS_W-1:0]  wdata,
  input  logic              wr,
  input  logic              rd,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              evt,
  output logic [BUS_W-1:0]  rdata,
  output tmr_mode_e         mode,
  output logic [1:0]        div_sel,
  output logic [CNT_W-1:0]  limit,
  output logic              clr,
  output logic              rd_lo,
  output logic              flag,
  output logic              flag_clr,
  output logic [BUS_W-1:0]  hold
);
  localparam int NBYTE = CNT_W / BUS_W;
  localparam logic [BUS_W-1:0] FLAG_MASK = BUS_W'(1);

  logic [BUS_W-1:0] ctrl_q;
  logic [BUS_W-1:0] lim_b [NBYTE];

  assign clr      = wr && (addr == A_CNT_LO);
  assign rd_lo    = rd && (addr == A_CNT_LO);
  assign flag_clr = wr && (addr == A_STAT) && ((wdata & FLAG_MASK) != '0);
  assign mode     = tmr_mode_e'(ctrl_q[1:0]);
  assign div_sel  = ctrl_q[3:2];

  always_ff @(posedge clk) begin
    if (!rst_n)                      ctrl_q <= '0;
    else if (wr && addr == A_CTRL)   ctrl_q <= wdata;
  end

  for (genvar b = 0; b < NBYTE; b++) begin : g_lim
    always_ff @(posedge clk) begin
      if (!rst_n)
        lim_b[b] <= '1;
      else if (wr && addr == ADDR_W'(int'(A_LIM_LO) + b))
        lim_b[b] <= wdata;
    end
    assign limit[b*BUS_W +: BUS_W] = lim_b[b];
  end

  // high byte is frozen on the low-byte read
  always_ff @(posedge clk) begin
    if (!rst_n)     hold <= '0;
    else if (rd_lo) hold <= cnt[CNT_W-1 -: BUS_W];
  end

  // a new event wins over a clear in the same cycle
  always_ff @(posedge clk) begin
    if (!rst_n)        flag <= 1'b0;
    else if (evt)      flag <= 1'b1;
    else if (flag_clr) flag <= 1'b0;
  end

  always_comb begin
    rdata = '0;
    if (rd) begin
      case (addr)
        A_CNT_LO: rdata = cnt[BUS_W-1:0];
        A_CNT_HI: rdata = hold;
        A_CTRL:   rdata = ctrl_q;
        A_LIM_LO: rdata = lim_b[0];
        A_LIM_HI: rdata = lim_b[NBYTE-1];
        A_STAT:   rdata = {{(BUS_W-1){1'b0}}, flag};
        default:  rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/tmr16_unit.sv
module tmr16_unit
  import tmr16_pkg::*;
#(
  parameter int BUS_W   = 8,
  parameter int DIV_MID = 8,
  parameter int DIV_MAX = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [BUS_W-1:0]  reg_wdata,
  input  logic              reg_wr,
  input  logic              reg_rd,
  output logic [BUS_W-1:0]  reg_rdata,
  output logic              irq
);
  localparam int CNT_W = 2 * BUS_W;

  tmr_mode_e        mode_q;
  logic [1:0]       div_sel;
  logic [CNT_W-1:0] limit;
  logic [CNT_W-1:0] cnt;
  logic             clr;
  logic             rd_lo;
  logic             tick;
  logic             evt;
  logic             flag;
  logic             flag_clr;
  logic [BUS_W-1:0] hold;
  logic             run;

  assign run = (mode_q != MD_STOP);
  assign irq = flag;

  tmr16_prescaler #(
    .DIV_MID (DIV_MID),
    .DIV_MAX (DIV_MAX)
  ) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .restart (clr),
    .div_sel (div_sel),
    .tick    (tick)
  );

  tmr16_counter #(
    .CNT_W (CNT_W)
  ) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick),
    .clr   (clr),
    .mode  (mode_q),
    .limit (limit),
    .cnt   (cnt),
    .evt   (evt)
  );

  tmr16_regfile #(
    .BUS_W (BUS_W),
    .CNT_W (CNT_W)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .wr       (reg_wr),
    .rd       (reg_rd),
    .cnt      (cnt),
    .evt      (evt),
    .rdata    (reg_rdata),
    .mode     (mode_q),
    .div_sel  (div_sel),
    .limit    (limit),
    .clr      (clr),
    .rd_lo    (rd_lo),
    .flag     (flag),
    .flag_clr (flag_clr),
    .hold     (hold)
  );

endmodule

// File: rtl/tmr16_unit_chk.sv
module tmr16_unit_chk
  import tmr16_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int BUS_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input tmr_mode_e        mode_q,
  input logic             tick,
  input logic             clr,
  input logic             rd_lo,
  input logic             evt,
  input logic             flag,
  input logic             flag_clr,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] limit,
  input logic [BUS_W-1:0] hold
);

  p_idle_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !clr) |=> $stable(cnt));

  p_free_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !clr && mode_q == MD_FREE && cnt != '1) |=> (cnt == $past(cnt) + 1'b1));

  p_tick_running_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> (mode_q != MD_STOP));

  p_stop_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MD_STOP && !clr) |=> $stable(cnt));

  p_mod_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !clr && mode_q == MD_MOD && cnt == limit) |=> (cnt == '0));

  p_snapshot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_lo |=> (hold == $past(cnt[CNT_W-1 -: BUS_W])));

  p_clear_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0));

  p_event_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> (flag && cnt == '0));

  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !flag_clr) |=> flag);

endmodule

bind tmr16_unit tmr16_unit_chk #(
  .CNT_W (CNT_W),
  .BUS_W (BUS_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .mode_q   (mode_q),
  .tick     (tick),
  .clr      (clr),
  .rd_lo    (rd_lo),
  .evt      (evt),
  .flag     (flag),
  .flag_clr (flag_clr),
  .cnt      (cnt),
  .limit    (limit),
  .hold     (hold)
);

// File: tb/tb_tmr16_unit.sv
`timescale 1ns/1ps
module tb_tmr16_unit;

  localparam logic [2:0] AD_LO   = 3'd0;
  localparam logic [2:0] AD_HI   = 3'd1;
  localparam logic [2:0] AD_CTRL = 3'd2;
  localparam logic [2:0] AD_LIML = 3'd3;
  localparam logic [2:0] AD_LIMH = 3'd4;
  localparam logic [2:0] AD_STAT = 3'd5;

  localparam logic [1:0] M_FREE = 2'b01;
  localparam logic [1:0] M_MOD  = 2'b10;
  localparam logic [1:0] M_UPDN = 2'b11;
  localparam logic [1:0] D_1    = 2'b00;
  localparam logic [1:0] D_8    = 2'b01;
  localparam logic [1:0] D_128  = 2'b10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic       reg_wr = 1'b0;
  logic       reg_rd = 1'b0;
  logic [7:0] reg_rdata;
  logic       irq;

  int n_chk = 0;
  int n_fail = 0;

  logic [7:0] exp_q [$];
  string      tag_q [$];

  always #10 clk = ~clk;

  tmr16_unit dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_rdata (reg_rdata),
    .irq       (irq)
  );

  // monitor: pops expected bytes as the design returns read data
  always @(negedge clk) begin
    if (rst_n && reg_rd) begin
      if (exp_q.size() == 0) begin
        n_chk++;
        n_fail++;
        $display("FAIL unexpected read actual=%h expected=none", reg_rdata);
      end else begin
        logic [7:0] e;
        string      t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_chk++;
        if (reg_rdata !== e) begin
          n_fail++;
          $display("FAIL %s actual=%h expected=%h", t, reg_rdata, e);
        end
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(posedge clk); #1;
    reg_addr = a; reg_rd = 1'b1;
    @(posedge clk); #1;
    reg_rd = 1'b0;
  endtask

  // counter runs for exactly m clock edges (m >= 2)
  task automatic run_for(input logic [1:0] md, input logic [1:0] dv, input int m);
    wr(AD_CTRL, {4'b0, dv, 2'b00});
    wr(AD_CTRL, {4'b0, dv, md});
    repeat (m - 2) @(posedge clk);
    wr(AD_CTRL, {4'b0, dv, 2'b00});
  endtask

  task automatic check_irq(input logic e, input string t);
    @(negedge clk);
    n_chk++;
    if (irq !== e) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", t, irq, e);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R10 reset state
    rd(AD_LO,   8'h00, "R10 count low");
    rd(AD_HI,   8'h00, "R10 hold");
    rd(AD_CTRL, 8'h00, "R10 control");
    rd(AD_LIML, 8'hFF, "R10 limit low");
    rd(AD_LIMH, 8'hFF, "R10 limit high");
    rd(AD_STAT, 8'h00, "R10 status");
    rd(3'd7,    8'h00, "R10 unused address");
    check_irq(1'b0, "R10 irq");

    // R1 free-running steps, R3 stop holds
    run_for(M_FREE, D_1, 10);
    rd(AD_LO, 8'h0A, "R1 free count after 10 ticks");
    rd(AD_HI, 8'h00, "R1 free high byte");
    repeat (20) @(posedge clk);
    rd(AD_LO, 8'h0A, "R3 stopped counter holds");
    rd(AD_CTRL, 8'h00, "R3 control stop readback");

    // R6 clear by low-byte write
    wr(AD_LO, 8'h5A);
    rd(AD_LO, 8'h00, "R6 low write clears");

    // R2 ratios
    run_for(M_FREE, D_8, 40);
    rd(AD_LO, 8'h05, "R2 ratio 8 over 40 edges");
    wr(AD_LO, 8'h00);
    run_for(M_FREE, D_128, 300);
    rd(AD_LO, 8'h02, "R2 ratio 128 over 300 edges");
    wr(AD_LO, 8'h00);

    // R9 prescaler restarts across stops
    run_for(M_FREE, D_8, 7);
    rd(AD_LO, 8'h00, "R9 seven edges at ratio 8");
    run_for(M_FREE, D_8, 7);
    rd(AD_LO, 8'h00, "R9 prescaler restarted after stop");
    run_for(M_FREE, D_8, 9);
    rd(AD_LO, 8'h01, "R9 full period gives one step");
    rd(AD_STAT, 8'h00, "R7 no event yet");

    // R4 modulo, R7 event, R8 sticky clear
    wr(AD_LIML, 8'h05);
    wr(AD_LIMH, 8'h00);
    wr(AD_LO, 8'h00);
    run_for(M_MOD, D_1, 14);
    rd(AD_LO, 8'h02, "R4 modulo 5 after 14 ticks");
    rd(AD_STAT, 8'h01, "R7 modulo wrap sets flag");
    check_irq(1'b1, "R7 irq follows flag");
    wr(AD_STAT, 8'h00);
    rd(AD_STAT, 8'h01, "R8 writing 0 keeps flag");
    wr(AD_STAT, 8'h01);
    rd(AD_STAT, 8'h00, "R8 writing 1 clears flag");
    check_irq(1'b0, "R8 irq cleared");

    // R4 up/down with direction kept across stops
    wr(AD_LIML, 8'h03);
    rd(AD_LIML, 8'h03, "R4 limit readback");
    wr(AD_LO, 8'h00);
    run_for(M_UPDN, D_1, 4);
    rd(AD_LO, 8'h02, "R4 up/down turned at limit");
    rd(AD_STAT, 8'h00, "R7 no flag at limit turn");
    run_for(M_UPDN, D_1, 2);
    rd(AD_LO, 8'h00, "R4 up/down back at zero");
    rd(AD_STAT, 8'h01, "R7 flag on return to zero");
    run_for(M_UPDN, D_1, 3);
    rd(AD_LO, 8'h03, "R4 up/down counting up again");
    wr(AD_STAT, 8'h01);

    // R1 full-range wrap, R5 coherent read pair
    wr(AD_LO, 8'h00);
    run_for(M_FREE, D_1, 65535);
    rd(AD_LO, 8'hFF, "R1 top low byte");
    rd(AD_HI, 8'hFF, "R5 top high byte");
    rd(AD_STAT, 8'h00, "R7 no flag before wrap");
    rd(AD_LO, 8'hFF, "R5 low read snapshots high");
    run_for(M_FREE, D_1, 2);
    rd(AD_HI, 8'hFF, "R5 hold keeps old high byte");
    rd(AD_STAT, 8'h01, "R7 overflow sets flag");
    rd(AD_LO, 8'h01, "R1 wrapped to zero then stepped");
    rd(AD_HI, 8'h00, "R5 new snapshot after low read");

    repeat (3) @(posedge clk);
    if (exp_q.size() != 0) begin
      n_chk++;
      n_fail++;
      $display("FAIL scoreboard actual=%0d pending expected=0", exp_q.size());
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule